// File: doc/BRIEF.md
# Wilkinson Conversion Latch Array

This block is the digital back end of a switched-capacitor waveform digitizer. A trigger starts one shared conversion counter, clocked by the counting clock, and raises a ramp-enable that the analog side uses to start its common ramp. Each storage cell has its own comparator stop input. When a cell's stop input first rises, that cell latches the counter value into its own result register. All cells convert at once against the same counter, and no cell waits for another.

The conversion window ends when the counter reaches full scale. A cell that saw no stop edge by then is given the full-scale code and an overflow flag. A request/acknowledge handshake then passes control to the readout clock domain. There, a serializer sends every cell's flag and code, cell 0 first, one bit per readout clock, with a frame marker on the very first bit. A one-cycle done pulse follows the last bit. The block then drops busy and returns to idle with every cell cleared.

Top module: `wilkinson_latch_array`

## Requirements
- R1: A trigger sampled high by the counting clock while the block is idle raises ramp_en and busy from that edge onward.
- R2: The shared counter starts at 0 on the trigger edge and advances by one per counting clock. ramp_en stays high for exactly 2^CODE_BITS counting clocks and then falls.
- R3: Each stop input passes through a two-flop synchronizer. A cell whose stop is first sampled high at an edge where the counter reads k stores the code k+2, provided k+2 does not exceed full scale. In that case its overflow flag is 0.
- R4: Only the first synchronized rising edge of a stop input counts in a conversion. Later falls and rises of that input leave the stored code unchanged.
- R5: A cell with no synchronized rising edge inside the window stores full scale (all ones) with its overflow flag set to 1. A stop input that is already high when the trigger arrives counts as having no edge.
- R6: Readout sends cells in ascending index order. Each cell gives a word of CODE_BITS+1 bits: the overflow flag first, then the code MSB first. Bits are sent back to back, one per readout clock. ser_frame is high only with the first bit of cell 0.
- R7: done is high for exactly one readout clock, in the cycle after the last bit.
- R8: A trigger arriving during conversion or readout neither restarts the counter nor starts another conversion or frame.
- R9: busy stays high from the trigger through the last serial bit. It falls after done, and the next trigger then starts a fresh conversion from cleared cells.
- R10: After reset, busy, ramp_en, ser_data, ser_frame and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cnt | input | 1 | Counting clock that drives the conversion counter |
| clk_rd | input | 1 | Readout clock for the serializer |
| rst_n | input | 1 | Synchronous active-low reset, seen in both clock domains |
| trig | input | 1 | Conversion trigger, synchronous to clk_cnt |
| stop_in | input | CELLS | Per-cell comparator stop levels, asynchronous |
| ramp_en | output | 1 | Common ramp enable, high during the conversion window |
| busy | output | 1 | High from trigger until readout is complete |
| ser_data | output | 1 | Serial result data (clk_rd domain) |
| ser_frame | output | 1 | Marks the first bit of cell 0 |
| done | output | 1 | One-cycle pulse after the last serial bit |

## Verification
The assertions take for granted that trig is synchronous to clk_cnt and that reset is held long enough to be seen by both clocks. They also assume that a stop level, once raised, stays in a state for at least two counting clocks, so that the synchronizer sees every edge. The bench therefore drives trig and stop_in only at falling edges of clk_cnt. It holds every stop level for three or more cycles, and it releases reset only after many cycles of both clocks. Because of this, the expected codes follow exactly from the cycle in which each stop is raised.

// File: rtl/wla_pkg.sv
// Shared state types for the Wilkinson conversion latch array.
package wla_pkg;
    typedef enum logic [1:0] {CS_IDLE, CS_CONV, CS_HAND, CS_DRAIN} conv_state_t;
    typedef enum logic [1:0] {RS_IDLE, RS_SHIFT, RS_FIN, RS_WAIT} rd_state_t;
endpackage

// File: rtl/wla_sync2.sv
// Two-flop level synchronizer.
// Assumes: d is a level held for at least two destination clocks.
module wla_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    // Move d into the clk domain through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/wla_cell.sv
// One storage cell's result latch: synchronizes its stop input, catches
// the first rising edge during the window and stores the shared count,
// or full scale with an overflow flag if no edge comes.
// Assumes: clr is high whenever the controller is idle.
module wla_cell #(
    parameter int CODE_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 run,
    input  logic                 last,
    input  logic                 stop_raw,
    input  logic [CODE_BITS-1:0] count,
    output logic [CODE_BITS-1:0] code,
    output logic                 ovf
);
    localparam logic [CODE_BITS-1:0] FULL = '1;

    logic [0:0] stop_s;
    logic       stop_prev;
    logic       got;

    wla_sync2 #(.WIDTH(1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (stop_raw),
        .q    (stop_s)
    );

    // Latch the count on the first synchronized rise, or full scale at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_prev <= 1'b0;
            got       <= 1'b0;
            code      <= '0;
            ovf       <= 1'b0;
        end else begin
            stop_prev <= stop_s[0];
            if (clr) begin
                got  <= 1'b0;
                code <= '0;
                ovf  <= 1'b0;
            end else if (run && !got) begin
                if (stop_s[0] && !stop_prev) begin
                    code <= count;
                    got  <= 1'b1;
                end else if (last) begin
                    code <= FULL;
                    ovf  <= 1'b1;
                    got  <= 1'b1;
                end
            end
        end
    end

    // R4: once a value is held, only a clear may change it
    p_hold_after_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (got && !clr) |=> $stable(code));

    // R5: an overflowed cell always reads full scale
    p_ovf_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (code == FULL));
endmodule

// File: rtl/wla_conv_ctrl.sv
// Conversion controller in the counting clock domain: starts the shared
// counter on a trigger and ends the window at full scale. It then raises a
// request to the readout domain and waits for the acknowledge to rise and
// fall before returning to idle.
// Assumes: trig is synchronous to clk; ack_raw comes from another domain.
module wla_conv_ctrl
    import wla_pkg::*;
#(
    parameter int CODE_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig,
    input  logic                 ack_raw,
    output logic [CODE_BITS-1:0] count,
    output logic                 run,
    output logic                 last,
    output logic                 clr,
    output logic                 busy,
    output logic                 ramp_en,
    output logic                 req
);
    localparam logic [CODE_BITS-1:0] FULL = '1;

    conv_state_t          state_q;
    logic [CODE_BITS-1:0] count_q;
    logic                 req_q;
    logic [0:0]           ack_s;

    wla_sync2 #(.WIDTH(1)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ack_raw),
        .q    (ack_s)
    );

    // Sequence idle -> convert -> handshake -> drain -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            count_q <= '0;
            req_q   <= 1'b0;
        end else begin
            case (state_q)
                CS_IDLE: begin
                    if (trig) begin
                        state_q <= CS_CONV;
                        count_q <= '0;
                    end
                end
                CS_CONV: begin
                    if (count_q == FULL) begin
                        state_q <= CS_HAND;
                        req_q   <= 1'b1;
                    end else begin
                        count_q <= count_q + 1'b1;
                    end
                end
                CS_HAND: begin
                    if (ack_s[0]) begin
                        state_q <= CS_DRAIN;
                        req_q   <= 1'b0;
                    end
                end
                default: begin
                    if (!ack_s[0]) state_q <= CS_IDLE;
                end
            endcase
        end
    end

    // Decode state into cell controls and block outputs.
    always_comb begin
        count   = count_q;
        run     = (state_q == CS_CONV);
        last    = run && (count_q == FULL);
        clr     = (state_q == CS_IDLE);
        busy    = (state_q != CS_IDLE);
        ramp_en = run;
        req     = req_q;
    end

    // R2: the counter steps by one each cycle inside the window
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |=> (count == $past(count) + 1'b1));

    // R8: a trigger in mid-window does not restart the count
    p_trig_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last && trig) |=> (run && count != '0));

    // R8: a trigger during handshake never opens a new window
    p_trig_no_reopen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !run && trig) |=> !run);

    // R9: the request holds until acknowledged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack_s[0]) |=> req);
endmodule

// File: rtl/wla_serializer.sv
// Readout serializer in the readout clock domain. On a synchronized request
// it shifts every cell word out, cell 0 first and MSB first, then pulses done
// and holds its acknowledge until the request drops.
// Assumes: words stay stable from request rise until acknowledge falls.
module wla_serializer
    import wla_pkg::*;
#(
    parameter int CELLS     = 256,
    parameter int WORD_BITS = 13
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_raw,
    input  logic [CELLS*WORD_BITS-1:0] words,
    output logic                       ser_data,
    output logic                       frame,
    output logic                       done,
    output logic                       ack
);
    localparam int CELL_W = (CELLS > 1) ? $clog2(CELLS) : 1;
    localparam int BIT_W  = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
    localparam logic [CELL_W-1:0] LAST_CELL = CELL_W'(CELLS - 1);
    localparam logic [BIT_W-1:0]  TOP_BIT   = BIT_W'(WORD_BITS - 1);

    rd_state_t         state_q;
    logic [CELL_W-1:0] cell_q;
    logic [BIT_W-1:0]  bit_q;
    logic [0:0]        req_s;
    logic              cur_bit;

    wla_sync2 #(.WIDTH(1)) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (req_raw),
        .q    (req_s)
    );

    // Pick the bit addressed by the cell and bit pointers.
    always_comb begin
        cur_bit = words[int'(cell_q) * WORD_BITS + int'(bit_q)];
    end

    // Walk cells and bits, then signal completion and finish the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RS_IDLE;
            cell_q   <= '0;
            bit_q    <= '0;
            ser_data <= 1'b0;
            frame    <= 1'b0;
            done     <= 1'b0;
            ack      <= 1'b0;
        end else begin
            case (state_q)
                RS_IDLE: begin
                    ser_data <= 1'b0;
                    frame    <= 1'b0;
                    if (req_s[0]) begin
                        state_q <= RS_SHIFT;
                        cell_q  <= '0;
                        bit_q   <= TOP_BIT;
                    end
                end
                RS_SHIFT: begin
                    ser_data <= cur_bit;
                    frame    <= (cell_q == '0) && (bit_q == TOP_BIT);
                    if (bit_q == '0) begin
                        bit_q <= TOP_BIT;
                        if (cell_q == LAST_CELL) state_q <= RS_FIN;
                        else                     cell_q  <= cell_q + 1'b1;
                    end else begin
                        bit_q <= bit_q - 1'b1;
                    end
                end
                RS_FIN: begin
                    ser_data <= 1'b0;
                    frame    <= 1'b0;
                    done     <= 1'b1;
                    ack      <= 1'b1;
                    state_q  <= RS_WAIT;
                end
                default: begin
                    done <= 1'b0;
                    if (!req_s[0]) begin
                        ack     <= 1'b0;
                        state_q <= RS_IDLE;
                    end
                end
            endcase
        end
    end

    // R7: done never lasts two readout clocks
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the frame marker is a single-cycle event
    p_frame_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame |=> !frame);

    // R6: no frame marker outside an active shift
    p_frame_in_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_IDLE) |=> !frame);
endmodule

// File: rtl/wilkinson_latch_array.sv
// Top of the Wilkinson conversion latch array. It holds one controller, CELLS
// result latches sharing one counter, and the readout serializer.
// Assumes: rst_n is held for several cycles of both clocks; trig is
// synchronous to clk_cnt; stop_in levels hold at least two clk_cnt cycles.
module wilkinson_latch_array
    import wla_pkg::*;
#(
    parameter int CELLS     = 256,
    parameter int CODE_BITS = 12
) (
    input  logic             clk_cnt,
    input  logic             clk_rd,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [CELLS-1:0] stop_in,
    output logic             ramp_en,
    output logic             busy,
    output logic             ser_data,
    output logic             ser_frame,
    output logic             done
);
    localparam int WORD_BITS = CODE_BITS + 1;

    logic [CODE_BITS-1:0]       count;
    logic                       run;
    logic                       last;
    logic                       clr;
    logic                       req;
    logic                       ack;
    logic [CELLS*WORD_BITS-1:0] words;

    wla_conv_ctrl #(.CODE_BITS(CODE_BITS)) u_ctrl (
        .clk    (clk_cnt),
        .rst_n  (rst_n),
        .trig   (trig),
        .ack_raw(ack),
        .count  (count),
        .run    (run),
        .last   (last),
        .clr    (clr),
        .busy   (busy),
        .ramp_en(ramp_en),
        .req    (req)
    );

    for (genvar g = 0; g < CELLS; g++) begin : g_cell
        logic [CODE_BITS-1:0] cell_code;
        logic                 cell_ovf;

        wla_cell #(.CODE_BITS(CODE_BITS)) u_cell (
            .clk     (clk_cnt),
            .rst_n   (rst_n),
            .clr     (clr),
            .run     (run),
            .last    (last),
            .stop_raw(stop_in[g]),
            .count   (count),
            .code    (cell_code),
            .ovf     (cell_ovf)
        );

        assign words[g*WORD_BITS +: WORD_BITS] = {cell_ovf, cell_code};
    end

    wla_serializer #(.CELLS(CELLS), .WORD_BITS(WORD_BITS)) u_ser (
        .clk     (clk_rd),
        .rst_n   (rst_n),
        .req_raw (req),
        .words   (words),
        .ser_data(ser_data),
        .frame   (ser_frame),
        .done    (done),
        .ack     (ack)
    );
endmodule

// File: tb/sim_wilkinson_latch_array.sv
// Bench: directed corner runs plus seeded random stop patterns; expected words
// are computed from the stop cycle of each cell.
module sim_wilkinson_latch_array;
    localparam int N    = 16;
    localparam int B    = 8;
    localparam int W    = B + 1;
    localparam int MAXC = (1 << B) - 1;

    logic         clk_cnt = 1'b0;
    logic         clk_rd  = 1'b0;
    logic         rst_n   = 1'b0;
    logic         trig    = 1'b0;
    logic [N-1:0] stop_in = '0;
    logic         ramp_en, busy, ser_data, ser_frame, done;

    int n_tests = 0;
    int n_fail  = 0;
    int rx_frames = 0;
    bit [N*W-1:0] rx_vec;
    bit rx_done_a, rx_done_b, rx_frame_extra, rx_busy_last;
    int stop_at [N];
    bit dbl [N];

    always #4 clk_cnt = ~clk_cnt;
    always #5 clk_rd  = ~clk_rd;

    wilkinson_latch_array #(.CELLS(N), .CODE_BITS(B)) u0 (
        .clk_cnt(clk_cnt), .clk_rd(clk_rd), .rst_n(rst_n), .trig(trig),
        .stop_in(stop_in), .ramp_en(ramp_en), .busy(busy),
        .ser_data(ser_data), .ser_frame(ser_frame), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_word(input int s);
        if (s >= 0 && s + 2 <= MAXC) return {1'b0, B'(s + 2)};
        return {1'b1, {B{1'b1}}};
    endfunction

    // Receiver: collect one frame of bits starting at the marker.
    initial begin
        forever begin
            @(negedge clk_rd);
            if (rst_n && ser_frame) begin
                rx_vec[0] = ser_data;
                rx_frame_extra = 1'b0;
                for (int k = 1; k < N*W; k++) begin
                    @(negedge clk_rd);
                    rx_vec[k] = ser_data;
                    if (ser_frame) rx_frame_extra = 1'b1;
                end
                rx_busy_last = busy;
                @(negedge clk_rd);
                rx_done_a = done;
                @(negedge clk_rd);
                rx_done_b = done;
                rx_frames++;
            end
        end
    end

    task automatic do_run(input string name);
        int frames_before;
        logic [W-1:0] act;
        logic [W-1:0] exp;
        @(negedge clk_cnt);
        check(busy == 1'b0, "R9", {name, " idle before trigger"}, busy, 0);
        for (int c = 0; c < N; c++) stop_in[c] = (stop_at[c] == -2);
        repeat (3) @(negedge clk_cnt);
        frames_before = rx_frames;
        trig = 1'b1;
        @(negedge clk_cnt);
        trig = 1'b0;
        check(ramp_en && busy, "R1", {name, " ramp_en/busy after trigger"},
              {ramp_en, busy}, 3);
        for (int j = 0; j <= MAXC + 4; j++) begin
            if (j > 0) @(negedge clk_cnt);
            for (int c = 0; c < N; c++) begin
                if (stop_at[c] >= 0) begin
                    if (j == stop_at[c]) stop_in[c] = 1'b1;
                    if (dbl[c] && j == stop_at[c] + 3) stop_in[c] = 1'b0;
                    if (dbl[c] && j == stop_at[c] + 6) stop_in[c] = 1'b1;
                end
            end
            if (j == 20) trig = 1'b1;           // R8 trigger mid-window
            if (j == 21) trig = 1'b0;
            if (j == MAXC + 2) trig = 1'b1;     // R8 trigger during handshake
            if (j == MAXC + 3) trig = 1'b0;
            if (j == MAXC) check(ramp_en == 1'b1, "R2", {name, " ramp_en at last count"}, ramp_en, 1);
            if (j == MAXC + 1) begin
                check(ramp_en == 1'b0, "R2", {name, " ramp_en after window"}, ramp_en, 0);
                check(busy == 1'b1, "R9", {name, " busy after window"}, busy, 1);
            end
        end
        stop_in = '0;
        while (rx_frames == frames_before) @(negedge clk_rd);
        check(rx_busy_last == 1'b1, "R9", {name, " busy at last bit"}, rx_busy_last, 1);
        check(rx_done_a && !rx_done_b, "R7", {name, " done pulse width"},
              {rx_done_a, rx_done_b}, 2);
        check(!rx_frame_extra, "R6", {name, " frame only on first bit"}, rx_frame_extra, 0);
        while (busy) @(negedge clk_cnt);
        repeat (30) @(negedge clk_cnt);
        check(!busy && !ramp_en && rx_frames == frames_before + 1, "R8",
              {name, " no extra conversion"}, rx_frames - frames_before, 1);
        for (int c = 0; c < N; c++) begin
            act = '0;
            for (int b = 0; b < W; b++) act = {act[W-2:0], rx_vec[c*W + b]};
            exp = exp_word(stop_at[c]);
            if (exp[W-1])
                check(act == exp, "R5", {name, " overflow cell word"}, int'(act), int'(exp));
            else if (dbl[c])
                check(act == exp, "R4", {name, " toggled cell word"}, int'(act), int'(exp));
            else
                check(act == exp, "R3", {name, " R6 ordered cell word"}, int'(act), int'(exp));
        end
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'd2024);
        repeat (10) @(negedge clk_rd);
        rst_n = 1'b1;
        @(negedge clk_cnt);
        check(!busy && !ramp_en && !ser_data && !ser_frame && !done, "R10",
              "outputs after reset",
              {busy, ramp_en, ser_data, ser_frame, done}, 0);

        // Directed corners.
        for (int c = 0; c < N; c++) begin
            stop_at[c] = c * 10;
            dbl[c] = 1'b0;
        end
        stop_at[0] = 0;
        stop_at[1] = -1;
        stop_at[2] = MAXC - 2;
        stop_at[3] = MAXC - 1;
        stop_at[4] = -2;
        stop_at[5] = 5;  dbl[5] = 1'b1;
        stop_at[6] = MAXC;
        stop_at[7] = 40; dbl[7] = 1'b1;
        do_run("directed corners");

        for (int c = 0; c < N; c++) begin
            stop_at[c] = -1;
            dbl[c] = 1'b0;
        end
        do_run("no stops");

        // Seeded random patterns.
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < N; c++) begin
                stop_at[c] = int'($urandom_range(MAXC + 2, 0)) - 1;
                dbl[c] = 1'($urandom_range(1, 0));
            end
            do_run("random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog: actual hang expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule